// File: doc/BRIEF.md
# Two-Way Address Translation Buffer with Page Permissions

This block keeps recently used page translations so that a 40-bit virtual address can be turned into a 36-bit physical address without walking the page table. Pages are 16 KB, so the low 14 address bits pass straight through. The upper 26 bits form the virtual page number, which is looked up in a two-way set-associative store of 256 entries. Each entry holds a valid flag, a dirty flag, a two-bit permission field, a tag and a 22-bit physical page number.

A lookup is purely combinational. It reports exactly one of three results: a hit with the physical address, a miss, or a permission fault. The lookup also checks whether the request is allowed for the current privilege and access type. A permitted write to a clean page marks that page dirty at the next clock edge. Translations are installed through a refill port and removed through an invalidate port. Both ports take effect on the next clock edge. They obey only kernel-mode requests: a user-mode request is dropped and flagged in the same cycle.

Top module: `tlb_xlate`

## Requirements
- R1: The physical address is the entry's page number followed by virtual address bits [13:0] unchanged. The set index is virtual address bits [20:14] and the tag is bits [39:21], so the same tag in another set does not match.
- R2: While a lookup is requested, exactly one of hit, miss and fault is high. Miss is high when no valid way of the indexed set holds the tag. With no lookup requested, all three are low.
- R3: Permission field bit 0 grants writes and bit 1 grants user-mode access. A write to a page with bit 0 clear faults in either mode. A user access to a page with bit 1 clear faults. Kernel accesses ignore bit 1.
- R4: The physical address output and the dirty output are zero unless the result is a hit.
- R5: A kernel refill writes the entry at the next edge. If the tag is already present in the set, that way is overwritten. Otherwise an empty way is used, with way 0 chosen first.
- R6: When both ways of a set are valid and the tag is new, a refill replaces the least recently used way. Every hit and every refill makes the touched way the most recent.
- R7: The dirty output reports the stored dirty flag of the hit entry. A permitted write hit sets that flag at the next edge. A faulting write leaves it unchanged.
- R8: A refill or invalidate requested in user mode changes no entry. It raises the privilege-error output in the same cycle.
- R9: A kernel invalidate clears the entry holding that page at the next edge. Later lookups of that page miss, while the other way of the set keeps its translation.
- R10: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all valid flags |
| lkValid | input | 1 | Lookup request |
| lkVaddr | input | 40 | Virtual address to translate |
| lkWrite | input | 1 | Lookup is a write |
| lkUser | input | 1 | Lookup issued in user mode |
| lkHit | output | 1 | Translation found and permitted |
| lkMiss | output | 1 | No matching entry |
| lkFault | output | 1 | Matching entry forbids this access |
| lkPaddr | output | 36 | Physical address on a hit, else zero |
| lkDirty | output | 1 | Dirty flag of the hit entry |
| fillValid | input | 1 | Refill request |
| fillVpn | input | 26 | Virtual page number to install |
| fillPpn | input | 22 | Physical page number to install |
| fillAccess | input | 2 | Permission field to install (bit0 write, bit1 user) |
| fillDirty | input | 1 | Initial dirty flag |
| fillUser | input | 1 | Refill issued in user mode |
| invValid | input | 1 | Invalidate request |
| invVpn | input | 26 | Virtual page number to remove |
| invUser | input | 1 | Invalidate issued in user mode |
| privErr | output | 1 | User-mode refill or invalidate was rejected |

## Verification
The bench builds the block with its default parameters: 40-bit virtual and 36-bit physical addresses, 14 offset bits and 128 sets of two ways. The tag and index boundaries therefore sit exactly where R1 places them. This lets the bench place two pages in one set and compare them with a page that has the same tag in a neighbouring set. It can then fill a set completely, so that the least-recently-used choice, the empty-way choice and the reuse of a matching way are each forced separately.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int WAYS = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic            doFill;
    logic            fillWay;
    logic            doInv;
    logic [WAYS-1:0] invMask;
    logic            doDirty;
    logic            hitWay;
    logic            touchLru;
  } tlbStrobe_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import tlb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lkValid,
  input  logic            lkWrite,
  input  logic            lkUser,
  input  logic [WAYS-1:0] lkMatch,
  input  logic [1:0]      lkAcc,
  input  logic            lkDirtySel,
  input  logic            fillValid,
  input  logic            fillUser,
  input  logic [WAYS-1:0] fillMatch,
  input  logic [WAYS-1:0] fillVld,
  input  logic            fillLru,
  input  logic            invValid,
  input  logic            invUser,
  input  logic [WAYS-1:0] invMatch,
  output logic            lkHit,
  output logic            lkMiss,
  output logic            lkFault,
  output logic            privErr,
  output tlbStrobe_t      strobe
);
  logic anyMatch, allowed, fillOk, invOk, victim;

  assign anyMatch = |lkMatch;
  // bit1 = user may touch, bit0 = writable
  assign allowed  = (!lkUser || lkAcc[1]) && (!lkWrite || lkAcc[0]);
  assign lkHit    = lkValid && anyMatch && allowed;
  assign lkFault  = lkValid && anyMatch && !allowed;
  assign lkMiss   = lkValid && !anyMatch;

  assign fillOk  = fillValid && !fillUser;
  assign invOk   = invValid && !invUser;
  assign privErr = (fillValid && fillUser) || (invValid && invUser);

  always_comb begin
    if (|fillMatch)      victim = fillMatch[1];
    else if (!fillVld[0]) victim = 1'b0;
    else if (!fillVld[1]) victim = 1'b1;
    else                  victim = fillLru;
  end

  always_comb begin
    strobe          = '0;
    strobe.doFill   = fillOk;
    strobe.fillWay  = victim;
    strobe.doInv    = invOk;
    strobe.invMask  = invOk ? invMatch : '0;
    strobe.hitWay   = lkMatch[1];
    strobe.touchLru = lkHit;
    strobe.doDirty  = lkHit && lkWrite && !lkDirtySel;
  end

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lkHit, lkMiss, lkFault}));
  p_user_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fillValid && fillUser) |-> (!strobe.doFill && privErr));
  p_fault_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lkFault |-> !strobe.doDirty);
  p_kernel_owns_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (invValid && invUser) |-> (strobe.invMask == '0));
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import tlb_pkg::*;
#(
  parameter int VPN_W = 26,
  parameter int PPN_W = 22,
  parameter int SETS  = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VPN_W-1:0] lkVpn,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic [1:0]      fillAcc,
  input  logic            fillDirty,
  input  logic [VPN_W-1:0] invVpn,
  input  tlbStrobe_t      strobe,
  output logic [WAYS-1:0] lkMatch,
  output logic [1:0]      lkAcc,
  output logic            lkDirtySel,
  output logic [PPN_W-1:0] lkPpn,
  output logic [WAYS-1:0] fillMatch,
  output logic [WAYS-1:0] fillVld,
  output logic            fillLru,
  output logic [WAYS-1:0] invMatch
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;

  logic [WAYS-1:0]  vldQ   [SETS];
  logic [WAYS-1:0]  dirtyQ [SETS];
  logic [1:0]       accQ   [SETS][WAYS];
  logic [TAG_W-1:0] tagQ   [SETS][WAYS];
  logic [PPN_W-1:0] ppnQ   [SETS][WAYS];
  logic             lruQ   [SETS];   // way to evict next

  logic [IDX_W-1:0] lkIdx, fillIdx, invIdx;
  logic [TAG_W-1:0] lkTag, fillTag, invTag;
  logic             selWay;

  assign lkIdx   = lkVpn[IDX_W-1:0];
  assign lkTag   = lkVpn[VPN_W-1:IDX_W];
  assign fillIdx = fillVpn[IDX_W-1:0];
  assign fillTag = fillVpn[VPN_W-1:IDX_W];
  assign invIdx  = invVpn[IDX_W-1:0];
  assign invTag  = invVpn[VPN_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign lkMatch[w]   = vldQ[lkIdx][w]   && (tagQ[lkIdx][w]   == lkTag);
    assign fillMatch[w] = vldQ[fillIdx][w] && (tagQ[fillIdx][w] == fillTag);
    assign invMatch[w]  = vldQ[invIdx][w]  && (tagQ[invIdx][w]  == invTag);
  end

  assign selWay     = lkMatch[1];
  assign lkAcc      = accQ[lkIdx][selWay];
  assign lkDirtySel = dirtyQ[lkIdx][selWay];
  assign lkPpn      = ppnQ[lkIdx][selWay];
  assign fillVld    = vldQ[fillIdx];
  assign fillLru    = lruQ[fillIdx];

  // valid and recency state: reset, refill wins over the rest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vldQ[s] <= '0;
        lruQ[s] <= 1'b0;
      end
    end else begin
      if (strobe.doInv)
        vldQ[invIdx] <= vldQ[invIdx] & ~strobe.invMask;
      if (strobe.touchLru)
        lruQ[lkIdx] <= ~strobe.hitWay;
      if (strobe.doFill) begin
        vldQ[fillIdx][strobe.fillWay] <= 1'b1;
        lruQ[fillIdx] <= ~strobe.fillWay;
      end
    end
  end

  // entry payload, no reset needed
  always_ff @(posedge clk) begin
    if (strobe.doDirty)
      dirtyQ[lkIdx][strobe.hitWay] <= 1'b1;
    if (strobe.doFill) begin
      tagQ[fillIdx][strobe.fillWay]   <= fillTag;
      ppnQ[fillIdx][strobe.fillWay]   <= fillPpn;
      accQ[fillIdx][strobe.fillWay]   <= fillAcc;
      dirtyQ[fillIdx][strobe.fillWay] <= fillDirty;
    end
  end

  p_fill_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.doFill |=> (vldQ[$past(fillIdx)][$past(strobe.fillWay)] &&
                       tagQ[$past(fillIdx)][$past(strobe.fillWay)] == $past(fillTag)));
  p_dirty_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doDirty && !strobe.doFill) |=> dirtyQ[$past(lkIdx)][$past(strobe.hitWay)]);
  p_inv_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doInv && !strobe.doFill) |=> ((vldQ[$past(invIdx)] & $past(strobe.invMask)) == '0));
  p_lru_moves_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.touchLru && !strobe.doFill) |=> (lruQ[$past(lkIdx)] != $past(strobe.hitWay)));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int VA_W   = 40,
  parameter int PA_W   = 36,
  parameter int PAGE_W = 14,
  parameter int SETS   = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lkValid,
  input  logic [VA_W-1:0] lkVaddr,
  input  logic            lkWrite,
  input  logic            lkUser,
  output logic            lkHit,
  output logic            lkMiss,
  output logic            lkFault,
  output logic [PA_W-1:0] lkPaddr,
  output logic            lkDirty,
  input  logic            fillValid,
  input  logic [VA_W-PAGE_W-1:0] fillVpn,
  input  logic [PA_W-PAGE_W-1:0] fillPpn,
  input  logic [1:0]      fillAccess,
  input  logic            fillDirty,
  input  logic            fillUser,
  input  logic            invValid,
  input  logic [VA_W-PAGE_W-1:0] invVpn,
  input  logic            invUser,
  output logic            privErr
);
  localparam int VPN_W = VA_W - PAGE_W;
  localparam int PPN_W = PA_W - PAGE_W;

  tlbStrobe_t      strobe;
  logic [WAYS-1:0] lkMatch, fillMatch, fillVld, invMatch;
  logic [1:0]      lkAcc;
  logic            lkDirtySel, fillLru;
  logic [PPN_W-1:0] lkPpn;

  tlb_datapath #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SETS(SETS)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .lkVpn(lkVaddr[VA_W-1:PAGE_W]), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillAcc(fillAccess), .fillDirty(fillDirty), .invVpn(invVpn),
    .strobe(strobe), .lkMatch(lkMatch), .lkAcc(lkAcc), .lkDirtySel(lkDirtySel),
    .lkPpn(lkPpn), .fillMatch(fillMatch), .fillVld(fillVld), .fillLru(fillLru),
    .invMatch(invMatch)
  );

  tlb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lkValid(lkValid), .lkWrite(lkWrite), .lkUser(lkUser),
    .lkMatch(lkMatch), .lkAcc(lkAcc), .lkDirtySel(lkDirtySel),
    .fillValid(fillValid), .fillUser(fillUser), .fillMatch(fillMatch),
    .fillVld(fillVld), .fillLru(fillLru),
    .invValid(invValid), .invUser(invUser), .invMatch(invMatch),
    .lkHit(lkHit), .lkMiss(lkMiss), .lkFault(lkFault), .privErr(privErr),
    .strobe(strobe)
  );

  assign lkPaddr = lkHit ? {lkPpn, lkVaddr[PAGE_W-1:0]} : '0;
  assign lkDirty = lkHit && lkDirtySel;

  p_quiet_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !lkHit |-> (lkPaddr == '0 && !lkDirty));
  p_offset_through_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lkHit |-> (lkPaddr[PAGE_W-1:0] == lkVaddr[PAGE_W-1:0]));
endmodule

// File: tb/tlb_xlate_bench.sv
module tlb_xlate_bench;
  localparam int PERIOD = 10;
  localparam logic [2:0] HIT = 3'b100, MIS = 3'b010, FLT = 3'b001;
  localparam int VW = 26 + 14 + 1 + 1 + 3 + 22 + 1;

  typedef struct packed {
    logic [25:0] vpn;
    logic [13:0] off;
    logic        wr;
    logic        usr;
    logic [2:0]  res;
    logic [21:0] ppn;
    logic        dirty;
  } vec_t;

  localparam logic [25:0] PA = 26'h0008005, PB = 26'h0010005, PC = 26'h0000389;
  localparam logic [25:0] PD = 26'h000088C, PE = 26'h0018005, PG = 26'h0002A89;
  localparam logic [25:0] PF = 26'h0000094, PN = 26'h0008006;

  localparam logic [VW-1:0] VECS [10] = '{
    {PA, 14'h1234, 1'b0, 1'b1, HIT, 22'h12345, 1'b0},
    {PA, 14'h3FFF, 1'b1, 1'b1, HIT, 22'h12345, 1'b0},
    {PB, 14'h0000, 1'b0, 1'b1, FLT, 22'h0,     1'b0},
    {PB, 14'h0042, 1'b0, 1'b0, HIT, 22'h0ABCD, 1'b0},
    {PB, 14'h0100, 1'b1, 1'b0, HIT, 22'h0ABCD, 1'b0},
    {PC, 14'h2000, 1'b0, 1'b1, HIT, 22'h3FFFF, 1'b1},
    {PC, 14'h0001, 1'b1, 1'b1, FLT, 22'h0,     1'b0},
    {PC, 14'h0002, 1'b1, 1'b0, FLT, 22'h0,     1'b0},
    {PE, 14'h0003, 1'b0, 1'b0, MIS, 22'h0,     1'b0},
    {PN, 14'h0004, 1'b0, 1'b1, MIS, 22'h0,     1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic lkValid = 0, lkWrite = 0, lkUser = 0;
  logic [39:0] lkVaddr = '0;
  logic lkHit, lkMiss, lkFault, lkDirty, privErr;
  logic [35:0] lkPaddr;
  logic fillValid = 0, fillDirty = 0, fillUser = 0;
  logic [25:0] fillVpn = '0, invVpn = '0;
  logic [21:0] fillPpn = '0;
  logic [1:0]  fillAccess = '0;
  logic invValid = 0, invUser = 0;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [2:0]  sRes;
  logic [35:0] sPaddr;
  logic        sDirty, sPriv;

  always #(PERIOD/2) clk = ~clk;

  tlb_xlate u_tlb_xlate (
    .clk(clk), .rst_n(rst_n), .lkValid(lkValid), .lkVaddr(lkVaddr),
    .lkWrite(lkWrite), .lkUser(lkUser), .lkHit(lkHit), .lkMiss(lkMiss),
    .lkFault(lkFault), .lkPaddr(lkPaddr), .lkDirty(lkDirty),
    .fillValid(fillValid), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillAccess(fillAccess), .fillDirty(fillDirty), .fillUser(fillUser),
    .invValid(invValid), .invVpn(invVpn), .invUser(invUser), .privErr(privErr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [25:0] vpn, input logic [13:0] off,
                      input logic wr, input logic usr);
    @(negedge clk);
    lkVaddr = {vpn, off}; lkWrite = wr; lkUser = usr; lkValid = 1'b1;
    #2;
    sRes = {lkHit, lkMiss, lkFault}; sPaddr = lkPaddr; sDirty = lkDirty;
    @(posedge clk); #1;
    lkValid = 1'b0; lkWrite = 1'b0; lkUser = 1'b0;
  endtask

  task automatic fill(input logic [25:0] vpn, input logic [21:0] ppn,
                      input logic [1:0] acc, input logic dty, input logic usr);
    @(negedge clk);
    fillVpn = vpn; fillPpn = ppn; fillAccess = acc; fillDirty = dty;
    fillUser = usr; fillValid = 1'b1;
    #2; sPriv = privErr;
    @(posedge clk); #1;
    fillValid = 1'b0; fillUser = 1'b0;
  endtask

  task automatic inval(input logic [25:0] vpn, input logic usr);
    @(negedge clk);
    invVpn = vpn; invUser = usr; invValid = 1'b1;
    #2; sPriv = privErr;
    @(posedge clk); #1;
    invValid = 1'b0; invUser = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10: empty after reset; R2 idle outputs
    #1;
    chk("R2 idle outputs", {lkHit, lkMiss, lkFault, privErr}, 4'b0000);
    look(PA, 14'h0, 1'b0, 1'b0);
    chk("R10 miss after reset", sRes, MIS);

    // setup: A,B share set 5; C in set 9; D user read-only clean
    fill(PA, 22'h12345, 2'b11, 1'b0, 1'b0);
    chk("R8 no flag for kernel refill", sPriv, 1'b0);
    fill(PB, 22'h0ABCD, 2'b01, 1'b0, 1'b0);
    fill(PC, 22'h3FFFF, 2'b10, 1'b1, 1'b0);
    fill(PD, 22'h00777, 2'b10, 1'b0, 1'b0);

    // table: R1 R2 R3 R4 R7
    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = vec_t'(VECS[i]);
      look(v.vpn, v.off, v.wr, v.usr);
      chk($sformatf("R2 R3 result row %0d", i), sRes, v.res);
      chk($sformatf("R1 R4 paddr row %0d", i), sPaddr,
          (v.res == HIT) ? {v.ppn, v.off} : 36'h0);
      chk($sformatf("R7 dirty row %0d", i), sDirty, v.dirty);
    end

    // R7: earlier permitted writes made A and B dirty
    look(PA, 14'h0010, 1'b0, 1'b0);
    chk("R7 A dirty after write", sDirty, 1'b1);
    look(PB, 14'h0010, 1'b0, 1'b0);
    chk("R7 B dirty after write", sDirty, 1'b1);
    // R7: faulting write leaves D clean
    look(PD, 14'h0005, 1'b1, 1'b1);
    chk("R3 write to read-only faults", sRes, FLT);
    look(PD, 14'h0005, 1'b0, 1'b0);
    chk("R7 faulted write left clean", {sRes, sDirty}, {HIT, 1'b0});

    // R6: touch A so B is least recent, then new tag evicts B
    look(PA, 14'h0, 1'b0, 1'b0);
    fill(PE, 22'h2AAAA, 2'b11, 1'b0, 1'b0);
    look(PB, 14'h0, 1'b0, 1'b0);
    chk("R6 LRU way B evicted", sRes, MIS);
    look(PA, 14'h0, 1'b0, 1'b0);
    chk("R6 A kept", sRes, HIT);
    look(PE, 14'h0ABC, 1'b0, 1'b1);
    chk("R6 E installed", sPaddr, {22'h2AAAA, 14'h0ABC});

    // R5: same tag overwrites in place; E survives
    fill(PA, 22'h01111, 2'b11, 1'b0, 1'b0);
    look(PA, 14'h0001, 1'b0, 1'b0);
    chk("R5 refill reuses way", sPaddr, {22'h01111, 14'h0001});
    look(PE, 14'h0, 1'b0, 1'b0);
    chk("R5 other way kept", sRes, HIT);
    // R5: empty way taken first; C in set 9 survives
    fill(PG, 22'h00042, 2'b11, 1'b0, 1'b0);
    look(PC, 14'h0, 1'b0, 1'b1);
    chk("R5 empty way used, C kept", sRes, HIT);
    look(PG, 14'h0, 1'b0, 1'b1);
    chk("R5 G installed", sRes, HIT);

    // R8: user refill / invalidate ignored and flagged
    fill(PF, 22'h00F0F, 2'b11, 1'b0, 1'b1);
    chk("R8 user refill flagged", sPriv, 1'b1);
    look(PF, 14'h0, 1'b0, 1'b0);
    chk("R8 user refill ignored", sRes, MIS);
    inval(PA, 1'b1);
    chk("R8 user invalidate flagged", sPriv, 1'b1);
    look(PA, 14'h0, 1'b0, 1'b0);
    chk("R8 user invalidate ignored", sRes, HIT);

    // R9: kernel invalidate
    inval(PA, 1'b0);
    chk("R9 no flag for kernel invalidate", sPriv, 1'b0);
    look(PA, 14'h0, 1'b0, 1'b0);
    chk("R9 invalidated page misses", sRes, MIS);
    look(PE, 14'h0, 1'b0, 1'b0);
    chk("R9 neighbour way kept", sRes, HIT);

    // R10: reset in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    look(PE, 14'h0, 1'b0, 1'b0);
    chk("R10 miss after second reset", sRes, MIS);

    finishRun();
  end
endmodule